// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It watches a free-running counter that lives outside the block and may be shared with other channels. It also watches one channel pin. Software picks one of three uses for the channel:

- an input capture that records the counter value on a chosen pin edge;
- an output compare that drives, clears or toggles the output pin when the counter reaches a stored value;
- a PWM-style output, where overflow of the counter toggles the pin and a max-duty control can hold the pin high.

Every event sets a flag, and the flag can raise an interrupt request. Clearing the flag takes a handshake: a read that sees the flag set, then a write of zero. An event that arrives between the read and the write keeps the flag set, so no event is lost.

Software uses a small register bus with a read strobe, a write strobe, an address and 8-bit data. Address 0 holds the 8-bit status/control register. Addresses 1 up to CNT_W/8 hold the channel value register, most significant byte first. The channel value register is the compare value, and the input capture overwrites it.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the status/control register reads 0x00, the channel value reads 0, the irq output is 0 and pin_out is 0.
- R2: The status/control bits are laid out as follows: bit 7 is the event flag, bit 6 the interrupt enable, bit 5 the buffer select (read/write storage only), bit 4 the mode select (0 = capture, 1 = compare), bits 3:2 the edge/action select, bit 1 toggle-on-overflow and bit 0 max duty. Bits 6..0 read back exactly as written. Address k (from 1 to CNT_W/8) reads and writes byte CNT_W/8-k of the channel value. Any other address reads 0.
- R3: While the edge/action select is 00, the channel is idle. No edge, match or overflow sets the flag or changes pin_out.
- R4: With mode select 0, an edge/action select of 01 captures rising edges, 10 captures falling edges and 11 captures both. The pin passes through two synchronizer flops. On the third rising clock edge after a pin change, the flag sets and the channel value takes the counter value present at that clock edge. A non-selected edge does nothing.
- R5: With mode select 1, the flag sets at the clock edge of the first cycle in which the counter equals the channel value. A counter that holds at that value produces no further event. At the same clock edge the output takes its action: 01 toggles it, 10 drives it low, 11 drives it high.
- R6: In compare mode with toggle-on-overflow set, each overflow pulse toggles the output. When an overflow and a compare event fall in the same cycle, only the compare action applies.
- R7: In compare mode with max duty set, pin_out is 1 whatever the compare events do. After max duty is cleared, pin_out shows the output level that those events produced.
- R8: A read of address 0 while the flag is 1, followed by a write to address 0 with bit 7 = 0, clears the flag.
- R9: An event after that read, or in the same cycle as the clearing write, leaves the flag set.
- R10: Writing 1 to bit 7 never changes the flag. A write of 0 without an earlier arming read leaves the flag set. Any write to address 0 that does not clear the flag cancels an armed clear.
- R11: irq is 1 exactly while the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | One-cycle pulse when the counter overflows |
| pin_in | input | 1 | Channel pin, asynchronous |
| pin_out | output | 1 | Channel pin drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with CNT_W = 8 and ADDR_W = 2. With these values the channel value fits in one byte, so every compare value from 0x00 to 0xFF can be reached by setting the counter directly. Address 2 then falls outside the map, which tests the read-zero rule.

The bench sweeps all three capture edge codes against both pin directions. It sweeps all three compare actions over values that include both ends of the counter range. It places events at exact cycles inside the clear handshake, including the cycle of the clearing write itself.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  // Bit positions inside the status/control byte
  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_BUF  = 5;
  localparam int unsigned BIT_MODE = 4;
  localparam int unsigned BIT_SELH = 3;
  localparam int unsigned BIT_SELL = 2;
  localparam int unsigned BIT_TOV  = 1;
  localparam int unsigned BIT_MAXD = 0;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       buf_sel;
    logic       mode;
    logic [1:0] sel;
    logic       tov;
    logic       maxd;
  } stat_t;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cmp_act_e;

  // Capture edge hit: sel bit 0 = rising, sel bit 1 = falling
  function automatic logic edge_hit(logic [1:0] sel, logic rise, logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

  // Output level after a compare event
  function automatic logic pin_next(logic [1:0] sel, logic cur);
    case (cmp_act_e'(sel))
      ACT_TOGGLE: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              synced;

  assign synced = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= synced;
    end
  end

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;

endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic st_rd,
  input  logic st_wr,
  input  logic wr_flag_bit,
  output logic flag_q,
  output logic armed_q
);

  logic clr_ok;

  assign clr_ok = st_wr & armed_q & ~wr_flag_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // A new event always wins over a clear
      if (ev)          flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      // Arming: a read that sees the flag; any event or status write disarms
      if (ev)                  armed_q <= 1'b0;
      else if (st_wr)          armed_q <= 1'b0;
      else if (st_rd & flag_q) armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tmr_pin_out.sv
module tmr_pin_out
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_mode,
  input  logic       cmp_ev,
  input  logic [1:0] sel,
  input  logic       tov,
  input  logic       maxd,
  input  logic       ovf,
  output logic       out_q,
  output logic       pin_out
);

  logic ovf_tgl;

  assign ovf_tgl = cmp_mode & tov & ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (cmp_ev) begin
      out_q <= pin_next(sel, out_q);
    end else if (ovf_tgl) begin
      out_q <= ~out_q;
    end
  end

  assign pin_out = (cmp_mode & maxd) | out_q;

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_ovf,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              irq
);

  localparam int unsigned NBYTES = CNT_W / 8;

  // Control bits (flag lives in the flag controller)
  logic             ie_q, buf_q, mode_q, tov_q, maxd_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] val_q;
  logic             match_d;

  // Named internal events
  logic st_sel, st_rd, st_wr;
  logic conn, cap_mode, cmp_mode;
  logic pin_rise, pin_fall;
  logic cap_ev, cmp_match, cmp_ev, ev;
  logic flag_q, armed_q, out_q;
  logic val_wr;
  stat_t stat;

  assign st_sel   = (bus_addr == '0);
  assign st_rd    = bus_rd & st_sel;
  assign st_wr    = bus_wr & st_sel;
  assign val_wr   = bus_wr & ~st_sel;

  assign conn     = |sel_q;
  assign cap_mode = conn & ~mode_q;
  assign cmp_mode = conn & mode_q;

  tmr_sync_edge #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin_in),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cap_ev    = cap_mode & edge_hit(sel_q, pin_rise, pin_fall);
  assign cmp_match = (cnt_val == val_q);
  assign cmp_ev    = cmp_mode & cmp_match & ~match_d;
  assign ev        = cap_ev | cmp_ev;

  tmr_flag_ctl u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .st_rd      (st_rd),
    .st_wr      (st_wr),
    .wr_flag_bit(bus_wdata[BIT_FLAG]),
    .flag_q     (flag_q),
    .armed_q    (armed_q)
  );

  tmr_pin_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_mode(cmp_mode),
    .cmp_ev  (cmp_ev),
    .sel     (sel_q),
    .tov     (tov_q),
    .maxd    (maxd_q),
    .ovf     (cnt_ovf),
    .out_q   (out_q),
    .pin_out (pin_out)
  );

  // Control register bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      buf_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= 2'b00;
      tov_q  <= 1'b0;
      maxd_q <= 1'b0;
    end else if (st_wr) begin
      ie_q   <= bus_wdata[BIT_IE];
      buf_q  <= bus_wdata[BIT_BUF];
      mode_q <= bus_wdata[BIT_MODE];
      sel_q  <= bus_wdata[BIT_SELH:BIT_SELL];
      tov_q  <= bus_wdata[BIT_TOV];
      maxd_q <= bus_wdata[BIT_MAXD];
    end
  end

  // Channel value: capture has priority over a CPU byte write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (cap_ev) begin
      val_q <= cnt_val;
    end else if (val_wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (bus_addr == ADDR_W'(b + 1))
          val_q[(NBYTES-1-b)*8 +: 8] <= bus_wdata;
      end
    end
  end

  // Previous match, for one event per equality run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_d <= 1'b0;
    else        match_d <= cmp_match;
  end

  assign stat = '{flag: flag_q, ie: ie_q, buf_sel: buf_q, mode: mode_q,
                  sel: sel_q, tov: tov_q, maxd: maxd_q};

  always_comb begin
    bus_rdata = 8'h00;
    if (st_sel) begin
      bus_rdata = stat;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (bus_addr == ADDR_W'(b + 1))
          bus_rdata = val_q[(NBYTES-1-b)*8 +: 8];
      end
    end
  end

  assign irq = flag_q & ie_q;

endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev,
  input logic             cap_ev,
  input logic             cmp_ev,
  input logic             conn,
  input logic             flag_q,
  input logic             armed_q,
  input logic             st_wr,
  input logic             wr_flag_bit,
  input logic             val_wr,
  input logic             out_q,
  input logic [CNT_W-1:0] val_q,
  input logic [CNT_W-1:0] cnt_val
);

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> flag_q); // R5

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q); // R10

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_flag_bit && !ev) |=> (flag_q == $past(flag_q))); // R10

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && ev) |=> (flag_q && !armed_q)); // R9

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (val_q == $past(cnt_val))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !conn |=> $stable(out_q)); // R3

  AST_ONE_EVENT_PER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ev && !val_wr) |=> !cmp_ev); // R5

endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev         (ev),
  .cap_ev     (cap_ev),
  .cmp_ev     (cmp_ev),
  .conn       (conn),
  .flag_q     (flag_q),
  .armed_q    (armed_q),
  .st_wr      (st_wr),
  .wr_flag_bit(bus_wdata[7]),
  .val_wr     (val_wr),
  .out_q      (out_q),
  .val_q      (val_q),
  .cnt_val    (cnt_val)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_ovf = 1'b0;
  logic          pin_in = 1'b0;
  logic          pin_out;
  logic          irq;

  int  checks = 0;
  int  fails = 0;
  bit  cnt_run = 1'b0;
  bit  exp_out = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan #(.CNT_W(CW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cnt_run) cnt_val = cnt_val + 8'd1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    step();
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic clr(logic [7:0] cfg);
    logic [7:0] d;
    rd(0, d);
    wr(0, cfg);
  endtask

  task automatic pin_toggle();
    step(); pin_in = ~pin_in;
    step(); step(); step();
  endtask

  // Reference compare action
  function automatic bit act_out(logic [1:0] a, bit cur);
    case (a)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] exp_val;
    logic [7:0] c;
    logic [7:0] vals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step();
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 pin_out", {7'd0, pin_out}, 8'h00);
    rd(0, d); chk("R1 status", d, 8'h00);
    rd(1, d); chk("R1 value", d, 8'h00);

    // R2 layout and map
    wr(1, 8'hAA);
    wr(0, 8'h7F);
    rd(0, d); chk("R2 status readback", d, 8'h7F);
    chk("R7 maxd forces pin", {7'd0, pin_out}, 8'h01);
    rd(1, d); chk("R2 value byte", d, 8'hAA);
    rd(2, d); chk("R2 unmapped 2", d, 8'h00);
    rd(3, d); chk("R2 unmapped 3", d, 8'h00);
    wr(0, 8'h00);
    rd(0, d); chk("R2 status cleared", d, 8'h00);
    exp_val = 8'hAA;

    // R3 idle channel: pin edges, matches, overflow
    wr(0, 8'h52);               // ie, mode=1, sel=00, tov
    pin_toggle(); pin_toggle();
    cnt_val = 8'hA8; cnt_run = 1'b1;
    repeat (4) step();
    cnt_run = 1'b0;
    step(); cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
    chk("R3 no flag", {7'd0, irq}, 8'h00);
    chk("R3 pin holds", {7'd0, pin_out}, {7'd0, exp_out});
    wr(0, 8'h40);
    pin_toggle();
    chk("R3 capture idle", {7'd0, irq}, 8'h00);
    rd(1, d); chk("R3 value kept", d, exp_val);

    // R4 capture sweep: edge code x direction
    for (int s = 1; s <= 3; s++) begin
      for (int r = 0; r <= 1; r++) begin
        bit hit;
        logic [7:0] cfg;
        cfg = 8'h40 | 8'(s << 2);
        hit = ((s & 1) != 0 && r == 1) || ((s & 2) != 0 && r == 0);
        wr(0, 8'h00);
        pin_in = (r == 1) ? 1'b0 : 1'b1;
        repeat (4) step();
        clr(8'h00);
        wr(0, cfg);
        cnt_val = 8'(8'h30 + 8'(s * 16) + 8'(r * 5));
        cnt_run = 1'b1;
        step(); pin_in = ~pin_in; c = cnt_val;
        step(); step();
        chk($sformatf("R4 sel%0d dir%0d no early flag", s, r), {7'd0, irq}, 8'h00);
        step();
        cnt_run = 1'b0;
        chk($sformatf("R4 sel%0d dir%0d flag", s, r), {7'd0, irq}, {7'd0, hit});
        if (hit) exp_val = c + 8'd2;
        rd(1, d);
        chk($sformatf("R4 sel%0d dir%0d value", s, r), d, exp_val);
        clr(cfg);
      end
    end
    wr(0, 8'h00);
    pin_in = 1'b0;
    repeat (4) step();
    clr(8'h00);

    // R5 compare sweep: action x value
    for (int a = 1; a <= 3; a++) begin
      for (int vi = 0; vi < 6; vi++) begin
        logic [7:0] cfg;
        cfg = 8'h50 | 8'(a << 2);
        cnt_val = vals[vi] - 8'd4;
        wr(1, vals[vi]);
        wr(0, cfg);
        cnt_run = 1'b1;
        while (cnt_val != vals[vi]) step();
        cnt_run = 1'b0;
        chk($sformatf("R5 act%0d val%h before", a, vals[vi]), {7'd0, irq}, 8'h00);
        step();
        exp_out = act_out(2'(a), exp_out);
        chk($sformatf("R5 act%0d val%h flag", a, vals[vi]), {7'd0, irq}, 8'h01);
        chk($sformatf("R5 act%0d val%h pin", a, vals[vi]), {7'd0, pin_out}, {7'd0, exp_out});
        repeat (3) step();
        chk($sformatf("R5 act%0d val%h single", a, vals[vi]), {7'd0, pin_out}, {7'd0, exp_out});
        clr(cfg);
        chk($sformatf("R8 act%0d val%h cleared", a, vals[vi]), {7'd0, irq}, 8'h00);
      end
    end

    // R6 toggle on overflow
    cnt_val = 8'h10;
    wr(1, 8'h90);
    wr(0, 8'h5E);
    for (int k = 0; k < 2; k++) begin
      step(); cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
      exp_out = ~exp_out;
      chk("R6 overflow toggle", {7'd0, pin_out}, {7'd0, exp_out});
    end
    if (!exp_out) begin
      step(); cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
      exp_out = 1'b1;
    end
    cnt_val = 8'h8F;
    step(); cnt_val = 8'h90; cnt_ovf = 1'b1;
    step(); cnt_ovf = 1'b0;
    chk("R6 compare wins over overflow", {7'd0, pin_out}, 8'h01);
    chk("R6 coincident flag", {7'd0, irq}, 8'h01);
    clr(8'h5E);

    // R7 max duty
    cnt_val = 8'h10;
    wr(0, 8'h19);               // compare, drive low, maxd
    step(); cnt_val = 8'h90;
    step();
    exp_out = 1'b0;
    chk("R7 pin held high", {7'd0, pin_out}, 8'h01);
    wr(0, 8'h18);
    chk("R7 pin after release", {7'd0, pin_out}, 8'h00);
    clr(8'h18);

    // R8/R10 handshake with capture on either edge
    wr(0, 8'h4C);
    pin_toggle();
    chk("R4 either edge flag", {7'd0, irq}, 8'h01);
    wr(0, 8'h4C);
    rd(0, d); chk("R10 write0 without read", d, 8'hCC);
    wr(0, 8'hCC);               // write 1: cancels the arm
    wr(0, 8'h4C);
    rd(0, d); chk("R10 arm cancelled", d, 8'hCC);
    clr(8'h4C);
    chk("R8 clear done", {7'd0, irq}, 8'h00);
    rd(0, d); chk("R8 status after clear", d, 8'h4C);
    wr(0, 8'hCC);
    rd(0, d); chk("R10 write1 no set", d, 8'h4C);

    // R9 event between read and write
    pin_toggle();
    rd(0, d);
    pin_toggle();
    wr(0, 8'h4C);
    chk("R9 event after read", {7'd0, irq}, 8'h01);
    clr(8'h4C);
    chk("R8 clear after R9", {7'd0, irq}, 8'h00);

    // R9 event in the same cycle as the clearing write
    cnt_val = 8'h00;
    wr(1, 8'h20);
    wr(0, 8'h54);
    step(); cnt_val = 8'h20;
    step();
    exp_out = ~exp_out;
    chk("R5 toggle event", {7'd0, irq}, 8'h01);
    cnt_val = 8'h00;
    rd(0, d);
    step();
    bus_wr = 1'b1; bus_addr = 0; bus_wdata = 8'h54; cnt_val = 8'h20;
    step();
    bus_wr = 1'b0;
    exp_out = ~exp_out;
    chk("R9 coincident write", {7'd0, irq}, 8'h01);
    chk("R5 second toggle", {7'd0, pin_out}, {7'd0, exp_out});

    // R11 interrupt gating
    wr(0, 8'h14);
    chk("R11 ie off", {7'd0, irq}, 8'h00);
    wr(0, 8'h54);
    chk("R11 ie on", {7'd0, irq}, 8'h01);
    clr(8'h54);
    chk("R11 flag off", {7'd0, irq}, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule